// File: doc/BRIEF.md
# Banked Configuration Register File

This block holds the configuration registers that a host reaches once an upstream unlock detector has placed the chip in configuration mode. The host writes a register number to an index port and then reads or writes that register through a data port. Most registers belong to one logical device. A device-select register chooses which device's bank the data port reaches. A small set of global registers can be reached whatever device is selected.

The registers drive per-function enables, a clock-source choice, a suspend flag and one activate flag per logical device. A write of the leave-configuration code to the control register sends a one-cycle exit pulse back to the unlock detector. While configuration mode is inactive, the block ignores host traffic and shows all-ones on its read data.

Top module: `cfg_regbank`

## Requirements
- R1: A write with `bus_port`=0 stores `bus_wdata` as the current index. Reading with `bus_port`=0 returns that index, and a later data-port access (`bus_port`=1) targets the register it names.
- R2: Index 0x07 is the 8-bit device-select register. It is readable and writable, and it resets to 0.
- R3: Index 0x30 is the activate register of the bank chosen by device select. Each bank 0..NUM_DEV-1 keeps its own 8-bit value. `dev_active[n]` equals bit 0 of bank n's value.
- R4: When device select is NUM_DEV or above, data-port writes to 0x30 change no bank, and a read of 0x30 returns 0x00.
- R5: Index 0x23 is a global register that can be reached under any device select. Its bits [3:0] drive `fn_enable` (bit 0 floppy, bit 1 first serial port, bit 2 second serial port, bit 3 parallel port). Its bit 4 drives `clk_alt` (0 selects the 24 MHz input).
- R6: Index 0x24 is a global register, and its bit 0 drives `suspend`.
- R7: A data-port write of 0x02 while the index is 0x02 makes `exit_pulse` high for exactly the one following cycle and clears the index to 0x00. Any other value written to 0x02 has no effect.
- R8: While `cfg_active` is 0, `rd_data` is 0xFF and writes to either port change nothing.
- R9: A data-port read of any index other than 0x07, 0x23, 0x24 or 0x30 returns 0x00, and a write to such an index changes no output.
- R10: After reset all registers are zero, so every output is 0 and `rd_data` follows R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_active | input | 1 | Configuration mode is open (from the unlock detector) |
| bus_wr | input | 1 | Single-cycle host write strobe |
| bus_port | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Host write data |
| rd_data | output | 8 | Read data for the port that `bus_port` selects |
| fn_enable | output | 4 | Function enables from global 0x23 |
| clk_alt | output | 1 | Clock-source select from global 0x23 bit 4 |
| suspend | output | 1 | Software suspend from global 0x24 bit 0 |
| dev_active | output | NUM_DEV | Bit 0 of each bank's activate register |
| exit_pulse | output | 1 | One-cycle request to leave configuration mode |

## Verification
Two things can fall in the same cycle: the data write that carries the exit code, and the index-register update it implies. The pulse and the index clear must take effect together, one edge after that write. The bench first writes a non-exit value to index 0x02 and checks that there is no pulse and that the index still reads 0x02. It then writes the exit code and checks that the pulse is present for exactly one cycle and that the index port reads 0x00 in that same cycle. It also sets up the case where the device select is changed and a bank write follows on the next cycle, and it checks that the write reaches only the newly selected bank.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;
  localparam int DW = 8;
  localparam logic [DW-1:0] IDX_CTRL  = 8'h02;
  localparam logic [DW-1:0] IDX_LDN   = 8'h07;
  localparam logic [DW-1:0] IDX_CLK   = 8'h23;
  localparam logic [DW-1:0] IDX_SUSP  = 8'h24;
  localparam logic [DW-1:0] IDX_ACT   = 8'h30;
  localparam logic [DW-1:0] EXIT_CODE = 8'h02;
  localparam logic [DW-1:0] RD_CLOSED = 8'hFF;
  localparam int FN_W = 4;
  localparam int CLK_ALT_BIT = 4;
endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
  import cfg_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_active,
  input  logic          bus_wr,
  input  logic          bus_port,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] idx_q,
  output logic          data_wr,
  output logic          exit_q
);
  logic [DW-1:0] idx_d;
  logic          exit_d;
  logic          acc_wr;

  assign acc_wr  = cfg_active & bus_wr;
  assign data_wr = acc_wr & bus_port;

  always_comb begin
    idx_d  = idx_q;
    exit_d = 1'b0;
    if (acc_wr) begin
      if (!bus_port) begin
        idx_d = bus_wdata;
      end else if (idx_q == IDX_CTRL && bus_wdata == EXIT_CODE) begin
        idx_d  = '0;
        exit_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      exit_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      exit_q <= exit_d;
    end
  end
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfg_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_wr,
  input  logic [DW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ldn_q,
  output logic [DW-1:0] clk_q,
  output logic [DW-1:0] susp_q
);
  logic ldn_en, clk_en, susp_en;

  assign ldn_en  = data_wr & (idx == IDX_LDN);
  assign clk_en  = data_wr & (idx == IDX_CLK);
  assign susp_en = data_wr & (idx == IDX_SUSP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldn_q  <= '0;
      clk_q  <= '0;
      susp_q <= '0;
    end else begin
      if (ldn_en)  ldn_q  <= wdata;
      if (clk_en)  clk_q  <= wdata;
      if (susp_en) susp_q <= wdata;
    end
  end
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_regbank_pkg::*;
#(
  parameter int DEV_ID = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_wr,
  input  logic [DW-1:0] idx,
  input  logic [DW-1:0] ldn,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] act_q
);
  localparam logic [DW-1:0] MY_LDN = DW'(DEV_ID);
  logic act_en;

  assign act_en = data_wr & (idx == IDX_ACT) & (ldn == MY_LDN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= '0;
    else if (act_en) act_q <= wdata;
  end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_regbank_pkg::*;
#(
  parameter int NUM_DEV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_active,
  input  logic               bus_wr,
  input  logic               bus_port,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      rd_data,
  output logic [FN_W-1:0]    fn_enable,
  output logic               clk_alt,
  output logic               suspend,
  output logic [NUM_DEV-1:0] dev_active,
  output logic               exit_pulse
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_sync_n;
  logic [DW-1:0]          idx_q, ldn_q, clk_q, susp_q, act_sel, reg_rd;
  logic                   data_wr;
  logic [DW-1:0]          act_arr [NUM_DEV];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[SYNC_STAGES-1];

  cfg_port_decode u_decode (
    .clk(clk), .rst_n(rst_sync_n), .cfg_active(cfg_active),
    .bus_wr(bus_wr), .bus_port(bus_port), .bus_wdata(bus_wdata),
    .idx_q(idx_q), .data_wr(data_wr), .exit_q(exit_pulse)
  );

  cfg_global_regs u_global (
    .clk(clk), .rst_n(rst_sync_n), .data_wr(data_wr), .idx(idx_q),
    .wdata(bus_wdata), .ldn_q(ldn_q), .clk_q(clk_q), .susp_q(susp_q)
  );

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
    cfg_dev_bank #(.DEV_ID(g)) u_bank (
      .clk(clk), .rst_n(rst_sync_n), .data_wr(data_wr), .idx(idx_q),
      .ldn(ldn_q), .wdata(bus_wdata), .act_q(act_arr[g])
    );
    assign dev_active[g] = act_arr[g][0];
  end

  always_comb begin
    act_sel = '0;
    for (int n = 0; n < NUM_DEV; n++) begin
      if (ldn_q == DW'(n)) act_sel = act_arr[n];
    end
  end

  always_comb begin
    case (idx_q)
      IDX_LDN:  reg_rd = ldn_q;
      IDX_CLK:  reg_rd = clk_q;
      IDX_SUSP: reg_rd = susp_q;
      IDX_ACT:  reg_rd = act_sel;
      default:  reg_rd = '0;
    endcase
  end

  assign rd_data   = !cfg_active ? RD_CLOSED : (bus_port ? reg_rd : idx_q);
  assign fn_enable = clk_q[FN_W-1:0];
  assign clk_alt   = clk_q[CLK_ALT_BIT];
  assign suspend   = susp_q[0];
endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk
  import cfg_regbank_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               cfg_active,
  input logic               bus_wr,
  input logic               bus_port,
  input logic [DW-1:0]      bus_wdata,
  input logic [DW-1:0]      idx_q,
  input logic [DW-1:0]      rd_data,
  input logic [NUM_DEV-1:0] dev_active,
  input logic               exit_pulse
);
  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_active && bus_wr && !bus_port) |=> idx_q == $past(bus_wdata));

  // R3
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(cfg_active && bus_wr && bus_port && idx_q == IDX_ACT) |=> $stable(dev_active));

  // R7
  exit_trigger_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_active && bus_wr && bus_port && idx_q == IDX_CTRL && bus_wdata == EXIT_CODE)
      |=> exit_pulse);

  // R7
  exit_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exit_pulse |=> !exit_pulse);

  // R7
  exit_clears_idx_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exit_pulse |-> idx_q == '0);

  // R8
  closed_reads_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_active |-> rd_data == RD_CLOSED);

  // R8
  closed_idx_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_active |=> $stable(idx_q));
endmodule

bind cfg_regbank cfg_regbank_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .cfg_active(cfg_active),
  .bus_wr(bus_wr), .bus_port(bus_port), .bus_wdata(bus_wdata),
  .idx_q(idx_q), .rd_data(rd_data), .dev_active(dev_active),
  .exit_pulse(exit_pulse)
);

// File: tb/test_cfg_regbank.sv
module test_cfg_regbank;
  localparam int ND = 4;

  logic          clk = 1'b0;
  logic          rst_n, cfg_active, bus_wr, bus_port;
  logic [7:0]    bus_wdata, rd_data;
  logic [3:0]    fn_enable;
  logic          clk_alt, suspend, exit_pulse;
  logic [ND-1:0] dev_active;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] m_act [ND];
  logic [7:0] m_clk, m_susp;

  always #5 clk = ~clk;

  cfg_regbank #(.NUM_DEV(ND)) i_cfg_regbank (
    .clk(clk), .rst_n(rst_n), .cfg_active(cfg_active), .bus_wr(bus_wr),
    .bus_port(bus_port), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .fn_enable(fn_enable), .clk_alt(clk_alt), .suspend(suspend),
    .dev_active(dev_active), .exit_pulse(exit_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic port, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_port = port; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic port, output logic [7:0] v);
    bus_port = port;
    #1;
    v = rd_data;
  endtask

  function automatic logic [3:0] exp_act_bits();
    logic [3:0] r;
    for (int n = 0; n < ND; n++) r[n] = m_act[n][0];
    return r;
  endfunction

  task automatic chk_outs(input string req);
    chk(req, fn_enable, m_clk[3:0]);
    chk(req, clk_alt, m_clk[4]);
    chk(req, suspend, m_susp[0]);
    chk(req, dev_active, exp_act_bits());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, e;
    rst_n = 1'b0; cfg_active = 1'b0; bus_wr = 1'b0; bus_port = 1'b0; bus_wdata = '0;
    for (int n = 0; n < ND; n++) m_act[n] = '0;
    m_clk = '0; m_susp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state, R8 closed read
    chk_outs("R10");
    chk("R10", exit_pulse, 0);
    rd(1'b1, v); chk("R8 closed read", v, 8'hFF);

    // R1 index latch
    cfg_active = 1'b1;
    wr(1'b0, 8'h23);
    rd(1'b0, v); chk("R1 index readback", v, 8'h23);
    rd(1'b1, v); chk("R10 global reset value", v, 0);
    // R2 reset value of device select
    wr(1'b0, 8'h07);
    rd(1'b1, v); chk("R2 reset", v, 0);
    wr(1'b0, 8'h23);

    // R8 writes ignored while closed
    cfg_active = 1'b0;
    wr(1'b0, 8'h30);
    wr(1'b1, 8'hFF);
    rd(1'b0, v); chk("R8 closed index read", v, 8'hFF);
    cfg_active = 1'b1;
    rd(1'b0, v); chk("R8 index unchanged", v, 8'h23);
    rd(1'b1, v); chk("R8 data unchanged", v, 0);
    chk_outs("R8");

    // R9/R5/R6/R3 sweep of the index space, device select 0
    for (int i = 0; i < 256; i++) begin
      logic [7:0] ix, d;
      ix = 8'(i);
      if (ix == 8'h02 || ix == 8'h07) continue;
      d = ix ^ 8'hA5;
      wr(1'b0, ix);
      wr(1'b1, d);
      case (ix)
        8'h23: m_clk = d;
        8'h24: m_susp = d;
        8'h30: m_act[0] = d;
        default: ;
      endcase
      case (ix)
        8'h23: e = m_clk;
        8'h24: e = m_susp;
        8'h30: e = m_act[0];
        default: e = 8'h00;
      endcase
      rd(1'b1, v); chk("R9 sweep read", v, e);
      chk(ix == 8'h23 ? "R5 enables" : "R9 enables", fn_enable, m_clk[3:0]);
      chk(ix == 8'h23 ? "R5 clk_alt" : "R9 clk_alt", clk_alt, m_clk[4]);
      chk(ix == 8'h24 ? "R6 suspend" : "R9 suspend", suspend, m_susp[0]);
      chk(ix == 8'h30 ? "R3 active" : "R9 active", dev_active, exp_act_bits());
    end

    // R2/R3/R4 bank sweep, device select 0..7
    for (int l = 0; l < 8; l++) begin
      logic [7:0] d;
      d = 8'((l * 37 + 1) & 8'hFF);
      wr(1'b0, 8'h07);
      wr(1'b1, 8'(l));
      rd(1'b1, v); chk("R2 select readback", v, l);
      wr(1'b0, 8'h30);
      wr(1'b1, d);
      if (l < ND) m_act[l] = d;
      rd(1'b1, v); chk(l < ND ? "R3 bank write" : "R4 out of range read", v, l < ND ? d : 0);
      chk(l < ND ? "R3 outputs" : "R4 outputs", dev_active, exp_act_bits());
    end
    for (int l = 0; l < 8; l++) begin
      wr(1'b0, 8'h07);
      wr(1'b1, 8'(l));
      wr(1'b0, 8'h30);
      rd(1'b1, v); chk(l < ND ? "R3 bank keeps" : "R4 read zero", v, l < ND ? m_act[l] : 0);
    end

    // R3 select change followed at once by a bank write
    wr(1'b0, 8'h07);
    wr(1'b1, 8'h02);
    wr(1'b0, 8'h30);
    wr(1'b1, 8'h00);
    m_act[2] = 8'h00;
    chk("R3 only selected bank", dev_active, exp_act_bits());

    // R5 global reached under out-of-range select
    wr(1'b0, 8'h07);
    wr(1'b1, 8'h05);
    wr(1'b0, 8'h23);
    wr(1'b1, 8'h0F);
    m_clk = 8'h0F;
    chk_outs("R5 global any select");
    chk("R5 clk_alt 24MHz", clk_alt, 0);

    // R7 exit handling
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h05);
    chk("R7 no exit for other value", exit_pulse, 0);
    rd(1'b0, v); chk("R7 index kept", v, 8'h02);
    wr(1'b1, 8'h02);
    chk("R7 exit pulse", exit_pulse, 1);
    rd(1'b0, v); chk("R7 index cleared", v, 8'h00);
    @(negedge clk);
    chk("R7 pulse one cycle", exit_pulse, 0);
    chk_outs("R7 registers kept");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule